// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to a usable state. When `start` is pulsed, it first holds clock enable low for a long guard interval. It then raises clock enable, issues a NOP and waits again. After that it issues a precharge-all command, then a burst of auto-refresh commands separated by short fixed gaps, then a load-mode-register command. A final settle wait ends the sequence, and the block reports completion.

A system controller pulses `start` once after reset and waits for `done` before it hands the memory to the normal access controller. Every command is driven for a single clock, with NOPs between commands. All wait lengths, the number of refresh commands and the mode register value are parameters. With the defaults, every interval in the sequence is at least two clocks long, and the address width is at least 11 bits.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rstN` is low, `cke`, `busy` and `done` are 0 and `csN`, `rasN`, `casN`, `weN` are all 1. From the first clock after reset, `csN` is 0.
- R2: Without a `start` pulse the block stays idle: `busy` is 0, `cke` is 0 and the bus shows NOP (`rasN`, `casN`, `weN` all 1).
- R3: `busy` rises one clock after the edge that samples `start` high. `cke` rises exactly GUARD_CYC clocks after `busy` rises, and it stays high until reset.
- R4: No command other than NOP appears while `cke` is low. The first command after `cke` rises is PRECHARGE, exactly NOP_WAIT clocks after the rise.
- R5: Command encodings on the bus are: NOP = `rasN`,`casN`,`weN` all 1; PRECHARGE = `rasN`=0, `casN`=1, `weN`=0; REFRESH = `rasN`=0, `casN`=0, `weN`=1; LOAD MODE = all three 0. PRECHARGE carries `addr` = 0x400 (bit 10 set, all banks).
- R6: Exactly REF_COUNT REFRESH commands follow PRECHARGE. Each one comes GAP_CYC clocks after the command before it.
- R7: LOAD MODE follows the last REFRESH by GAP_CYC clocks and carries `addr` = MODE_VAL. The default is 0x020: CAS latency 2, sequential burst, burst length 1.
- R8: `done` rises exactly SETTLE_CYC clocks after LOAD MODE. `busy` falls in the same clock, and `done` then stays high until reset.
- R9: `start` is ignored while `busy` is high and after `done`. A pulse in either phase leaves the timing, the commands and the outputs unchanged.
- R10: Every command is held for one clock only and is followed by NOP. A sequence contains exactly REF_COUNT+2 non-NOP commands.
- R11: The refresh burst length follows the REF_COUNT parameter. An instance built with 15 issues 15 refreshes with the same gap timing.
- R12: Asserting reset in the middle of a sequence returns the block to idle. A later `start` replays the whole sequence from the guard wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the initialization sequence (taken only when idle) |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row address strobe, active low |
| casN | output | 1 | Column address strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The checker enforces the properties that must hold on every clock. It checks that clock enable never drops outside reset and that no command is driven while clock enable is low. It checks that each command lasts one clock, that `done` is sticky and never overlaps `busy`, and that `busy` only ends as `done` rises. The exact intervals are measured only by the directed scenarios: guard, NOP wait, refresh gaps and settle time. The same holds for the command order, the refresh count in both burst configurations, the precharge and mode addresses, and the replay after a mid-sequence reset. These scenarios also show that a `start` pulse during a run or after completion leaves the run unchanged.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  // Command code: bit0 = row strobe, bit1 = column strobe, bit2 = write (active high)
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_REF = 3'd3,
    CMD_PRE = 3'd5,
    CMD_MRS = 3'd7
  } sdCmd_e;

  typedef enum logic [1:0] {
    LEN_GUARD,
    LEN_NOPWAIT,
    LEN_GAP,
    LEN_SETTLE
  } waitSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GUARD,
    ST_NOP,
    ST_NOPWAIT,
    ST_PRE,
    ST_PREGAP,
    ST_REF,
    ST_REFGAP,
    ST_MRS,
    ST_SETTLE,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    sdCmd_e   cmd;
    logic     ckeOn;
    logic     busyOn;
    logic     doneOn;
    logic     cntLoad;
    waitSel_e cntSel;
    logic     refLoad;
    logic     refDec;
  } seqStrobe_t;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cntZero,
  input  logic       refsDone,
  output seqStrobe_t stb
);

  seqState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (start) stateNxt = ST_GUARD;
      ST_GUARD:   if (cntZero) stateNxt = ST_NOP;
      ST_NOP:     stateNxt = ST_NOPWAIT;
      ST_NOPWAIT: if (cntZero) stateNxt = ST_PRE;
      ST_PRE:     stateNxt = ST_PREGAP;
      ST_PREGAP:  if (cntZero) stateNxt = ST_REF;
      ST_REF:     stateNxt = ST_REFGAP;
      ST_REFGAP:  if (cntZero) stateNxt = refsDone ? ST_MRS : ST_REF;
      ST_MRS:     stateNxt = ST_SETTLE;
      ST_SETTLE:  if (cntZero) stateNxt = ST_DONE;
      ST_DONE:    stateNxt = ST_DONE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.cmd     = CMD_NOP;
    stb.ckeOn   = 1'b1;
    stb.busyOn  = 1'b1;
    stb.doneOn  = 1'b0;
    stb.cntLoad = 1'b0;
    stb.cntSel  = LEN_GAP;
    stb.refLoad = 1'b0;
    stb.refDec  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.ckeOn  = 1'b0;
        stb.busyOn = 1'b0;
        if (start) begin
          stb.cntLoad = 1'b1;
          stb.cntSel  = LEN_GUARD;
        end
      end
      ST_GUARD: stb.ckeOn = 1'b0;
      ST_NOP: begin
        stb.cntLoad = 1'b1;
        stb.cntSel  = LEN_NOPWAIT;
      end
      ST_PRE: begin
        stb.cmd     = CMD_PRE;
        stb.cntLoad = 1'b1;
        stb.cntSel  = LEN_GAP;
        stb.refLoad = 1'b1;
      end
      ST_REF: begin
        stb.cmd     = CMD_REF;
        stb.cntLoad = 1'b1;
        stb.cntSel  = LEN_GAP;
        stb.refDec  = 1'b1;
      end
      ST_MRS: begin
        stb.cmd     = CMD_MRS;
        stb.cntLoad = 1'b1;
        stb.cntSel  = LEN_SETTLE;
      end
      ST_DONE: begin
        stb.busyOn = 1'b0;
        stb.doneOn = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdinit_dpath.sv
module sdinit_dpath
  import sdinit_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int GUARD_CYC  = 50000,
  parameter int NOP_WAIT   = 10000,
  parameter int GAP_CYC    = 10,
  parameter int SETTLE_CYC = 10000,
  parameter int REF_COUNT  = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL = 'h020
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  output logic              cntZero,
  output logic              refsDone,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);

  localparam int MAX_A   = (GUARD_CYC > NOP_WAIT) ? GUARD_CYC : NOP_WAIT;
  localparam int MAX_B   = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1) + 1;
  localparam int REF_W   = $clog2(REF_COUNT + 1) + 1;
  localparam int PRE_BIT = 10;

  logic [CNT_W-1:0]  cnt, cntInit;
  logic [REF_W-1:0]  refCnt;
  logic [2:0]        cmdBits;
  logic [2:0]        pinN;
  logic [ADDR_W-1:0] addrNxt;

  always_comb begin
    unique case (stb.cntSel)
      LEN_GUARD:   cntInit = CNT_W'(GUARD_CYC - 1);
      LEN_NOPWAIT: cntInit = CNT_W'(NOP_WAIT - 2);
      LEN_GAP:     cntInit = CNT_W'(GAP_CYC - 2);
      default:     cntInit = CNT_W'(SETTLE_CYC - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (stb.cntLoad)    cnt <= cntInit;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             refCnt <= '0;
    else if (stb.refLoad)  refCnt <= REF_W'(REF_COUNT);
    else if (stb.refDec)   refCnt <= refCnt - 1'b1;
  end

  assign refsDone = (refCnt == '0);

  always_comb begin
    unique case (stb.cmd)
      CMD_PRE: addrNxt = ADDR_W'(1) << PRE_BIT;
      CMD_MRS: addrNxt = MODE_VAL;
      default: addrNxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= CMD_NOP;
      addr    <= '0;
      cke     <= 1'b0;
      csN     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      cmdBits <= stb.cmd;
      addr    <= addrNxt;
      cke     <= stb.ckeOn;
      csN     <= 1'b0;
      busy    <= stb.busyOn;
      done    <= stb.doneOn;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_pin
    assign pinN[i] = ~cmdBits[i];
  end

  assign rasN = pinN[0];
  assign casN = pinN[1];
  assign weN  = pinN[2];

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int GUARD_CYC  = 50000,
  parameter int NOP_WAIT   = 10000,
  parameter int GAP_CYC    = 10,
  parameter int SETTLE_CYC = 10000,
  parameter int REF_COUNT  = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL = 'h020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);

  seqStrobe_t stb;
  logic       cntZero;
  logic       refsDone;

  sdinit_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cntZero  (cntZero),
    .refsDone (refsDone),
    .stb      (stb)
  );

  sdinit_dpath #(
    .ADDR_W     (ADDR_W),
    .GUARD_CYC  (GUARD_CYC),
    .NOP_WAIT   (NOP_WAIT),
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .REF_COUNT  (REF_COUNT),
    .MODE_VAL   (MODE_VAL)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cntZero  (cntZero),
    .refsDone (refsDone),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .addr     (addr),
    .busy     (busy),
    .done     (done)
  );

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk (
  input logic clk,
  input logic rstN,
  input logic cke,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic busy,
  input logic done
);

  // R3
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rstN) !$fell(cke));

  // R4
  no_cmd_without_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (rasN && casN && weN));

  // R10
  single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN || !weN) |=> (rasN && casN && weN));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $rose(done));

  // R3
  done_has_cke_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cke);

endmodule

bind sdram_init_seq sdinit_chk chk_i (
  .clk  (clk),
  .rstN (rstN),
  .cke  (cke),
  .rasN (rasN),
  .casN (casN),
  .weN  (weN),
  .busy (busy),
  .done (done)
);

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;

  localparam int AW  = 13;
  localparam int G   = 40;
  localparam int NW  = 20;
  localparam int GP  = 4;
  localparam int STL = 30;
  localparam logic [AW-1:0] MV = 13'h020;
  localparam int LIMIT = 600;

  logic clk = 1'b0;
  logic rstN;
  logic startA, startB;
  logic sel;

  logic ckeA, csNA, rasNA, casNA, weNA, busyA, doneA;
  logic ckeB, csNB, rasNB, casNB, weNB, busyB, doneB;
  logic [AW-1:0] addrA, addrB;

  logic oCke, oCsN, oRasN, oCasN, oWeN, oBusy, oDone;
  logic [AW-1:0] oAddr;

  int nChk = 0;
  int nFail = 0;

  int cmdT[48];
  int cmdC[48];
  int cmdA[48];
  int nCmd, tBusy, tCke, tDone, tBusyFall;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .GUARD_CYC(G), .NOP_WAIT(NW), .GAP_CYC(GP),
                   .SETTLE_CYC(STL), .REF_COUNT(8), .MODE_VAL(MV)) dut_i (
    .clk(clk), .rstN(rstN), .start(startA), .cke(ckeA), .csN(csNA),
    .rasN(rasNA), .casN(casNA), .weN(weNA), .addr(addrA),
    .busy(busyA), .done(doneA));

  sdram_init_seq #(.ADDR_W(AW), .GUARD_CYC(G), .NOP_WAIT(NW), .GAP_CYC(GP),
                   .SETTLE_CYC(STL), .REF_COUNT(15), .MODE_VAL(MV)) dut15_i (
    .clk(clk), .rstN(rstN), .start(startB), .cke(ckeB), .csN(csNB),
    .rasN(rasNB), .casN(casNB), .weN(weNB), .addr(addrB),
    .busy(busyB), .done(doneB));

  always_comb begin
    if (sel) begin
      oCke = ckeB; oCsN = csNB; oRasN = rasNB; oCasN = casNB; oWeN = weNB;
      oAddr = addrB; oBusy = busyB; oDone = doneB;
    end else begin
      oCke = ckeA; oCsN = csNA; oRasN = rasNA; oCasN = casNA; oWeN = weNA;
      oAddr = addrA; oBusy = busyA; oDone = doneA;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setStart(input bit useB, input logic v);
    if (useB) startB = v;
    else      startA = v;
  endtask

  function automatic int busCode();
    return {29'd0, ~oWeN, ~oCasN, ~oRasN};
  endfunction

  task automatic runSeq(input bit useB, input int nref, input bit pulseMid, input string tag);
    logic pBusy, pCke, pDone;
    sel = useB;
    @(negedge clk);
    setStart(useB, 1'b1);
    @(negedge clk);
    setStart(useB, 1'b0);
    nCmd = 0; tBusy = -1; tCke = -1; tDone = -1; tBusyFall = -1;
    pBusy = oBusy; pCke = oCke; pDone = oDone;
    for (int t = 1; t <= LIMIT; t++) begin
      @(negedge clk);
      if (oBusy && !pBusy) tBusy = t;
      if (!oBusy && pBusy) tBusyFall = t;
      if (oCke && !pCke) tCke = t;
      if (oDone && !pDone) tDone = t;
      if (busCode() != 0 && nCmd < 48) begin
        cmdT[nCmd] = t; cmdC[nCmd] = busCode(); cmdA[nCmd] = int'(oAddr);
        nCmd++;
      end
      pBusy = oBusy; pCke = oCke; pDone = oDone;
      if (pulseMid && (t == G / 2 || t == tCke + 3 || t == tCke + NW + 2))
        setStart(useB, 1'b1);
      else
        setStart(useB, 1'b0);
      if (tDone >= 0 && t >= tDone + 3) break;
    end
    setStart(useB, 1'b0);
    // R3: busy one clock after start, guard length
    checkEq({tag, " R3 busy rise"}, tBusy, 1);
    checkEq({tag, " R3 guard length"}, tCke - tBusy, G);
    // R10: command count
    checkEq({tag, " R10 command count"}, nCmd, nref + 2);
    if (nCmd == nref + 2) begin
      // R4 / R5: precharge timing, code and address
      checkEq({tag, " R4 precharge after cke"}, cmdT[0] - tCke, NW);
      checkEq({tag, " R5 precharge code"}, cmdC[0], 5);
      checkEq({tag, " R5 precharge addr"}, cmdA[0], 'h400);
      // R6: refresh burst
      for (int k = 1; k <= nref; k++) begin
        checkEq({tag, $sformatf(" R6 refresh %0d code", k)}, cmdC[k], 3);
        checkEq({tag, $sformatf(" R6 refresh %0d gap", k)}, cmdT[k] - cmdT[k-1], GP);
      end
      // R7: load mode
      checkEq({tag, " R7 mode code"}, cmdC[nref+1], 7);
      checkEq({tag, " R7 mode addr"}, cmdA[nref+1], int'(MV));
      checkEq({tag, " R7 mode gap"}, cmdT[nref+1] - cmdT[nref], GP);
      // R8: settle and completion
      checkEq({tag, " R8 settle length"}, tDone - cmdT[nref+1], STL);
    end
    checkEq({tag, " R8 busy falls with done"}, tBusyFall, tDone);
    checkEq({tag, " R8 done held"}, int'(oDone), 1);
  endtask

  task automatic testReset();
    rstN = 1'b0; startA = 1'b0; startB = 1'b0; sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    checkEq("R1 cke in reset", int'(oCke), 0);
    checkEq("R1 busy in reset", int'(oBusy), 0);
    checkEq("R1 done in reset", int'(oDone), 0);
    checkEq("R1 csN in reset", int'(oCsN), 1);
    checkEq("R1 cmd pins in reset", int'({oRasN, oCasN, oWeN}), 7);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 csN after reset", int'(oCsN), 0);
  endtask

  task automatic testIdle();
    int bad = 0;
    sel = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (oBusy || oCke || oDone || busCode() != 0) bad++;
    end
    // R2: idle without start
    checkEq("R2 idle cycles with activity", bad, 0);
  endtask

  task automatic testStartAfterDone();
    int bad = 0;
    sel = 1'b0;
    @(negedge clk);
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (oBusy || !oDone || !oCke || busCode() != 0) bad++;
    end
    // R9: start after done has no effect
    checkEq("R9 start after done", bad, 0);
  endtask

  task automatic testMidReset();
    sel = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startA = 1'b1;
    @(negedge clk);
    startA = 1'b0;
    repeat (G + 8) @(negedge clk);
    checkEq("R12 cke up before abort", int'(oCke), 1);
    rstN = 1'b0;
    @(negedge clk);
    // R12: abort returns to idle
    checkEq("R12 cke after abort", int'(oCke), 0);
    checkEq("R12 busy after abort", int'(oBusy), 0);
    checkEq("R12 done after abort", int'(oDone), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    checkEq("R12 idle after abort", int'(oBusy) + int'(oCke), 0);
    runSeq(1'b0, 8, 1'b0, "R12 replay");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    testReset();
    testIdle();
    runSeq(1'b0, 8, 1'b1, "R9 pulses during run");
    testStartAfterDone();
    runSeq(1'b1, 15, 1'b0, "R11 fifteen refreshes");
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule